// File: doc/BRIEF.md
# 100BASE-X Receive Symbol Framer

This block sits behind clock and data recovery on a 100 Mb/s fiber receive path. It takes one recovered bit at a time, already converted from NRZI to plain NRZ, and qualified by an enable. It then finds where 5-bit code groups begin and turns them into 4-bit nibbles for a MAC-side receive interface. The bit stream is all ones while the line is quiet. The first zero starts a carrier check. The framer must first see the opening delimiter symbol J and then K, and only then does it lock symbol alignment and start passing nibbles through. It outputs two ordinary preamble nibbles in place of the delimiter pair. The closing pair T then R ends the frame.

A one-cycle strobe marks each nibble. A frame-level data-valid signal and a carrier-sense level travel with the nibbles. A one-cycle error pulse marks each bad code group. Two sticky flags record events between polls: a false carrier, meaning a zero that did not lead to a good J/K pair, and an invalid symbol. Software-side logic clears both flags with a single clear input.

The control path is a five-state machine. IDLE moves to J_CHECK on a zero. J_CHECK moves to K_CHECK when the window is J, and otherwise returns to IDLE and raises false carrier. K_CHECK moves to DATA when the symbol is K, and otherwise returns to IDLE and raises false carrier. DATA moves to T_SEEN on T, returns to IDLE on an idle code group, and stays in DATA on any other symbol. T_SEEN always returns to IDLE when its symbol completes.

Top module: `fx_rx_framer`

## Requirements
- R1: While only ones arrive, crs stays 0 and no strobe or error pulse is produced; after reset every output is 0.
- R2: Bits are taken most significant first. On the first zero seen in idle, the 5-bit window is the two bits before that zero, the zero itself and the two bits after it. If that window equals 11000 (J), crs goes to 1 on the edge that takes the last of those bits, and symbol alignment is fixed there. Any other window value sets false_carrier and returns to idle without raising crs.
- R3: The next aligned symbol must be 10001 (K). Otherwise false_carrier is set, crs returns to 0, and no nibble is output.
- R4: When K is confirmed, two nibbles of value 4'h5 are strobed on two consecutive clock cycles, and rx_dv rises with the first of them. J and K themselves are never output, and every nibble strobe occurs while rx_dv is 1.
- R5: Data code groups decode with the standard 4B5B table, for example 11110→0, 01001→1, 10100→2, 01010→4, 11100→E and 11101→F. Each decoded nibble is strobed once, in order.
- R6: The symbol T (01101) clears rx_dv, and the following R (00111) clears crs. Neither symbol produces a nibble.
- R7: Inside a frame, any code group that is neither data, T nor idle (the halt 00100, J, K, R or an unused code) gives a one-cycle rx_err pulse with no strobe and sets bad_symbol. The frame then continues.
- R8: An idle code group 11111 inside a frame, before T, gives a one-cycle rx_err pulse and drops rx_dv and crs together. It does not set bad_symbol.
- R9: A T that is not followed by R gives an rx_err pulse, sets bad_symbol and drops crs.
- R10: false_carrier and bad_symbol stay at 1 until flag_clr is high on a clock edge, which clears them both.
- R11: A bit presented while bit_en is 0 is ignored and does not advance the framer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Qualifies bit_in for this cycle |
| bit_in | input | 1 | Recovered NRZ bit |
| flag_clr | input | 1 | Clears both sticky flags |
| rx_stb | output | 1 | One-cycle strobe for rx_nib |
| rx_nib | output | 4 | Decoded or preamble nibble |
| rx_dv | output | 1 | Frame data valid level |
| rx_err | output | 1 | One-cycle bad-symbol pulse |
| crs | output | 1 | Carrier sense level |
| false_carrier | output | 1 | Sticky false-carrier flag |
| bad_symbol | output | 1 | Sticky invalid-symbol flag |

## Verification
The assertions check on every cycle that these relations hold:
- every nibble strobe falls inside rx_dv, and rx_dv falls inside crs;
- an error pulse never carries a strobe;
- only the preamble pair is strobed back to back;
- a newly raised false carrier coincides with carrier being down;
- both flags hold until cleared.

Whether J, K, T and R are recognised at the right bit alignment, whether decoding is correct, and how the framer reacts to idle or a missing R mid-frame can only be shown by the bench. It compares the ordered stream of nibbles and error pulses against sequences it builds itself, with gaps inserted in bit_en.

// File: rtl/fx_rx_pkg.sv
package fx_rx_pkg;
    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    typedef logic [SYM_W-1:0] sym_t;
    typedef logic [NIB_W-1:0] nib_t;

    localparam sym_t SYM_J    = 5'b11000;
    localparam sym_t SYM_K    = 5'b10001;
    localparam sym_t SYM_T    = 5'b01101;
    localparam sym_t SYM_R    = 5'b00111;
    localparam sym_t SYM_IDLE = 5'b11111;
    localparam nib_t NIB_PRE  = 4'h5;

    typedef enum logic [2:0] {
        ST_IDLE, ST_JCHK, ST_KCHK, ST_DATA, ST_TSEEN
    } fr_state_t;

    typedef enum logic [2:0] {
        SC_DATA, SC_J, SC_K, SC_T, SC_R, SC_IDLE, SC_BAD
    } sym_cls_t;
endpackage

// File: rtl/fx_rx_shift.sv
module fx_rx_shift #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bit_en,
    input  logic         bit_in,
    input  logic         align,
    output logic [W-1:0] sym_now,
    output logic [$clog2(W)-1:0] cnt,
    output logic         sym_done
);
    localparam int CW = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [W-2:0] hist;

    // Window completed by the bit presented this cycle (oldest bit in MSB).
    assign sym_now  = {hist, bit_in};
    assign sym_done = bit_en && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist <= '1;
            cnt  <= '0;
        end else if (bit_en) begin
            hist <= sym_now[W-2:0];
            cnt  <= (align || cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fx_rx_symdec.sv
module fx_rx_symdec
    import fx_rx_pkg::*;
(
    input  sym_t     sym,
    output sym_cls_t cls,
    output nib_t     nib
);
    always_comb begin
        cls = SC_DATA;
        nib = '0;
        unique case (sym)
            5'b11110: nib = 4'h0;
            5'b01001: nib = 4'h1;
            5'b10100: nib = 4'h2;
            5'b10101: nib = 4'h3;
            5'b01010: nib = 4'h4;
            5'b01011: nib = 4'h5;
            5'b01110: nib = 4'h6;
            5'b01111: nib = 4'h7;
            5'b10010: nib = 4'h8;
            5'b10011: nib = 4'h9;
            5'b10110: nib = 4'hA;
            5'b10111: nib = 4'hB;
            5'b11010: nib = 4'hC;
            5'b11011: nib = 4'hD;
            5'b11100: nib = 4'hE;
            5'b11101: nib = 4'hF;
            SYM_J:    cls = SC_J;
            SYM_K:    cls = SC_K;
            SYM_T:    cls = SC_T;
            SYM_R:    cls = SC_R;
            SYM_IDLE: cls = SC_IDLE;
            default:  cls = SC_BAD;
        endcase
    end
endmodule

// File: rtl/fx_rx_framer.sv
module fx_rx_framer
    import fx_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       bit_in,
    input  logic       flag_clr,
    output logic       rx_stb,
    output logic [3:0] rx_nib,
    output logic       rx_dv,
    output logic       rx_err,
    output logic       crs,
    output logic       false_carrier,
    output logic       bad_symbol
);
    localparam int CW = $clog2(SYM_W);

    fr_state_t state, nxt;
    sym_t      sym_now;
    logic [CW-1:0] cnt;
    logic      sym_done, align, pre_pend;
    sym_cls_t  cls;
    nib_t      dnib;

    // In idle every bit is a boundary; in the J check the window closes two bits after the zero.
    logic j_done;
    assign j_done = (state == ST_JCHK) && bit_en && (cnt == CW'(1));
    assign align  = (state == ST_IDLE) || j_done;

    fx_rx_shift #(.W(SYM_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .align(align), .sym_now(sym_now), .cnt(cnt), .sym_done(sym_done)
    );

    fx_rx_symdec u_dec (.sym(sym_now), .cls(cls), .nib(dnib));

    logic fc_set, bad_set;
    assign fc_set  = (j_done && sym_now != SYM_J) ||
                     (state == ST_KCHK && sym_done && sym_now != SYM_K);
    assign bad_set = (state == ST_DATA && sym_done &&
                      (cls == SC_J || cls == SC_K || cls == SC_R || cls == SC_BAD)) ||
                     (state == ST_TSEEN && sym_done && cls != SC_R);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (bit_en && !bit_in) nxt = ST_JCHK;
            ST_JCHK:  if (j_done) nxt = (sym_now == SYM_J) ? ST_KCHK : ST_IDLE;
            ST_KCHK:  if (sym_done) nxt = (sym_now == SYM_K) ? ST_DATA : ST_IDLE;
            ST_DATA:  if (sym_done) begin
                          if (cls == SC_T)         nxt = ST_TSEEN;
                          else if (cls == SC_IDLE) nxt = ST_IDLE;
                      end
            ST_TSEEN: if (sym_done) nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_stb        <= 1'b0;
            rx_nib        <= '0;
            rx_dv         <= 1'b0;
            rx_err        <= 1'b0;
            crs           <= 1'b0;
            false_carrier <= 1'b0;
            bad_symbol    <= 1'b0;
            pre_pend      <= 1'b0;
        end else begin
            rx_stb   <= 1'b0;
            rx_err   <= 1'b0;
            pre_pend <= 1'b0;
            if (fc_set)        false_carrier <= 1'b1;
            else if (flag_clr) false_carrier <= 1'b0;
            if (bad_set)       bad_symbol <= 1'b1;
            else if (flag_clr) bad_symbol <= 1'b0;
            unique case (state)
                ST_IDLE: ;
                ST_JCHK: if (j_done && sym_now == SYM_J) crs <= 1'b1;
                ST_KCHK: if (sym_done) begin
                    if (sym_now == SYM_K) begin
                        rx_stb   <= 1'b1;
                        rx_nib   <= NIB_PRE;
                        rx_dv    <= 1'b1;
                        pre_pend <= 1'b1;
                    end else begin
                        crs <= 1'b0;
                    end
                end
                ST_DATA: begin
                    if (pre_pend) begin
                        rx_stb <= 1'b1;
                        rx_nib <= NIB_PRE;
                    end
                    if (sym_done) begin
                        unique case (cls)
                            SC_DATA: begin rx_stb <= 1'b1; rx_nib <= dnib; end
                            SC_T:    rx_dv <= 1'b0;
                            SC_IDLE: begin rx_err <= 1'b1; rx_dv <= 1'b0; crs <= 1'b0; end
                            SC_J, SC_K, SC_R, SC_BAD: rx_err <= 1'b1;
                        endcase
                    end
                end
                ST_TSEEN: if (sym_done) begin
                    crs <= 1'b0;
                    if (cls != SC_R) rx_err <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/fx_rx_framer_chk.sv
module fx_rx_framer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       flag_clr,
    input logic       rx_stb,
    input logic [3:0] rx_nib,
    input logic       rx_dv,
    input logic       rx_err,
    input logic       crs,
    input logic       false_carrier,
    input logic       bad_symbol
);
    assert_stb_in_dv_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |-> rx_dv);

    assert_dv_in_crs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dv |-> crs);

    assert_err_no_stb_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |-> !rx_stb);

    assert_preamble_pair_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_stb && $past(rx_stb)) |-> (rx_nib == 4'h5 && $past(rx_nib) == 4'h5));

    assert_fc_no_carrier_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(false_carrier) |-> (!crs && !rx_dv));

    assert_fc_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (false_carrier && !flag_clr) |=> false_carrier);

    assert_bad_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_symbol && !flag_clr) |=> bad_symbol);
endmodule

bind fx_rx_framer fx_rx_framer_chk u_chk (
    .clk(clk), .rst_n(rst_n), .flag_clr(flag_clr), .rx_stb(rx_stb),
    .rx_nib(rx_nib), .rx_dv(rx_dv), .rx_err(rx_err), .crs(crs),
    .false_carrier(false_carrier), .bad_symbol(bad_symbol)
);

// File: tb/fx_rx_framer_test.sv
module fx_rx_framer_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bit_en = 1'b0;
    logic bit_in = 1'b1;
    logic flag_clr = 1'b0;
    logic rx_stb, rx_dv, rx_err, crs, false_carrier, bad_symbol;
    logic [3:0] rx_nib;

    int checks = 0;
    int errors = 0;
    int dv_viol = 0;
    bit gaps = 1'b0;
    bit done = 1'b0;
    int evq[$];
    int expq[$];

    localparam logic [4:0] J = 5'b11000, K = 5'b10001, T = 5'b01101,
                           R = 5'b00111, I = 5'b11111, H = 5'b00100;
    localparam int ERR_EV = 16;

    always #2 clk = ~clk;

    fx_rx_framer uut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .flag_clr(flag_clr), .rx_stb(rx_stb), .rx_nib(rx_nib), .rx_dv(rx_dv),
        .rx_err(rx_err), .crs(crs), .false_carrier(false_carrier),
        .bad_symbol(bad_symbol)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_stb) begin
                evq.push_back(int'(rx_nib));
                if (!rx_dv) dv_viol++;
            end
            if (rx_err) evq.push_back(ERR_EV);
        end
    end

    function automatic logic [4:0] enc(input int n);
        case (n)
            0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
            4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
            8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
            12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick_bit(input logic b);
        if (gaps && ($urandom % 4 == 0)) begin
            bit_en = 1'b0;
            bit_in = ~b;
            @(negedge clk);
        end
        bit_en = 1'b1;
        bit_in = b;
        @(negedge clk);
        bit_en = 1'b0;
        bit_in = 1'b1;
    endtask

    task automatic send_sym(input logic [4:0] s);
        for (int i = 4; i >= 0; i--) tick_bit(s[i]);
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) tick_bit(1'b1);
    endtask

    task automatic pulse_clr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic compare_events(input string tag);
        check(evq.size() == expq.size(), {tag, " event count"}, evq.size(), expq.size());
        for (int i = 0; i < expq.size() && i < evq.size(); i++)
            check(evq[i] == expq[i], {tag, " event value"}, evq[i], expq[i]);
        evq.delete();
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7301));
        repeat (3) @(negedge clk);
        check({rx_stb, rx_dv, rx_err, crs, false_carrier, bad_symbol} == 6'b0,
              "R1 reset outputs", {rx_stb, rx_dv, rx_err, crs, false_carrier, bad_symbol}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: idle line
        send_ones(40);
        check(crs == 1'b0, "R1 crs idle", crs, 0);
        compare_events("R1 idle");

        // R2 R4 R5 R6: directed frame with all sixteen nibbles, stepwise levels
        send_ones(6);
        send_sym(J);
        check(crs == 1'b1 && rx_dv == 1'b0, "R2 crs after J", {crs, rx_dv}, 2);
        send_sym(K);
        check(rx_dv == 1'b1, "R4 dv after K", rx_dv, 1);
        expq.push_back(5); expq.push_back(5);
        for (int n = 0; n < 16; n++) begin
            send_sym(enc(n));
            expq.push_back(n);
        end
        send_sym(T);
        check(rx_dv == 1'b0 && crs == 1'b1, "R6 after T", {crs, rx_dv}, 2);
        send_sym(R);
        check(crs == 1'b0, "R6 crs after R", crs, 0);
        send_ones(8);
        compare_events("R5 full table");

        // R3: J followed by a non-K symbol
        send_sym(J);
        send_sym(I);
        send_ones(6);
        check(false_carrier == 1'b1 && crs == 1'b0, "R3 bad K", {false_carrier, crs}, 2);
        compare_events("R3 no nibbles");

        // R10: clear
        pulse_clr();
        check(false_carrier == 1'b0, "R10 clear", false_carrier, 0);

        // R2: window 11010 is not J
        send_sym(5'b11010);
        send_ones(6);
        check(false_carrier == 1'b1 && crs == 1'b0, "R2 bad J", {false_carrier, crs}, 2);
        compare_events("R2 no nibbles");
        send_ones(4);
        check(false_carrier == 1'b1, "R10 fc holds", false_carrier, 1);
        pulse_clr();

        // R7: halt symbol mid-frame, frame continues
        send_sym(J); send_sym(K); send_sym(enc(1)); send_sym(H); send_sym(enc(2));
        send_sym(T); send_sym(R); send_ones(6);
        expq = '{5, 5, 1, ERR_EV, 2};
        compare_events("R7 halt");
        check(bad_symbol == 1'b1, "R7 sticky bad", bad_symbol, 1);
        pulse_clr();
        check(bad_symbol == 1'b0, "R10 bad clear", bad_symbol, 0);

        // R8: idle mid-frame
        send_sym(J); send_sym(K); send_sym(enc(3)); send_sym(I);
        check(crs == 1'b0 && rx_dv == 1'b0, "R8 drop", {crs, rx_dv}, 0);
        send_ones(6);
        expq = '{5, 5, 3, ERR_EV};
        compare_events("R8 idle in frame");
        check(bad_symbol == 1'b0, "R8 no sticky", bad_symbol, 0);

        // R9: T without R
        send_sym(J); send_sym(K); send_sym(enc(4)); send_sym(T); send_sym(I);
        check(crs == 1'b0, "R9 crs", crs, 0);
        send_ones(6);
        expq = '{5, 5, 4, ERR_EV};
        compare_events("R9 missing R");
        check(bad_symbol == 1'b1, "R9 sticky", bad_symbol, 1);
        pulse_clr();

        // R5 R11: random frames with enable gaps
        gaps = 1'b1;
        for (int f = 0; f < 30; f++) begin
            int len;
            len = 1 + int'($urandom % 20);
            send_ones(2 + int'($urandom % 6));
            send_sym(J); send_sym(K);
            expq.push_back(5); expq.push_back(5);
            for (int k = 0; k < len; k++) begin
                int n;
                n = int'($urandom % 16);
                send_sym(enc(n));
                expq.push_back(n);
            end
            send_sym(T); send_sym(R);
            send_ones(3);
            compare_events("R11 random frame");
            check(crs == 1'b0 && rx_dv == 1'b0, "R6 random end", {crs, rx_dv}, 0);
        end
        gaps = 1'b0;
        check(false_carrier == 1'b0 && bad_symbol == 1'b0, "R1 no spurious flags",
              {false_carrier, bad_symbol}, 0);
        check(dv_viol == 0, "R4 strobes inside dv", dv_viol, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule